// File: doc/BRIEF.md
# ADC Trigger and Result Interface

This block is the digital control that sits around a 10-bit successive-approximation converter. It decides when a conversion begins and where each finished result goes. A conversion can be started by software or by an automatic trigger. The automatic trigger source is chosen with a 4-bit code: continuous back-to-back conversion, one of six flag-latched event sources, or one of two unlatched asynchronous event sources. The analog part is modelled outside the block. The block sends it a start pulse, and the analog part answers with a done pulse that carries 10 bits of data.

The finished result is held in a register pair that software reads one byte at a time. A layout select places the result either right-aligned or left-aligned within the two bytes. Reading the low byte locks the pair until the high byte is read. This stops a new completion from tearing a 10-bit read into halves taken from two different results.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset `busy` and `conv_start` are low, and both result bytes read as 0x00.
- R2: A `sw_start` sampled while idle makes `conv_start` a one-cycle pulse in the next cycle and sets `busy`. `busy` stays high until the edge at which `conv_done` is sampled. A `sw_start` sampled while busy has no effect.
- R3: With `trig_sel` = 0 and `auto_en` high, a `conv_done` sampled at edge k clears `busy`, and `conv_start` pulses after edge k+1. When `auto_en` is low, no new conversion follows.
- R4: Codes 1, 2, 3, 4, 7 and 8 are flagged sources, each watching `trig_ev` bit (code−1). An event pulse latches a flag. When the flag of the selected source is set, `auto_en` is high and the block is idle, a conversion starts one edge after the latch and the flag is cleared. An event that arrives while busy stays pending and starts a conversion one edge after `busy` falls.
- R5: Codes 5 and 6 are unlatched sources on `trig_ev` bits 4 and 5. An event sampled while idle starts a conversion at that same edge. An event sampled while busy is dropped.
- R6: Codes 9 to 15 never start a conversion automatically. Events on bits other than the selected source's bit, or any event while `auto_en` is low, start nothing.
- R7: With `left_adj` low, the low byte (`rd_hi`=0) is result[7:0] and the high byte is {6'b0, result[9:8]}. `rd_data` always shows the byte picked by `rd_hi`.
- R8: With `left_adj` high, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R9: A low-byte read (`rd_en`=1, `rd_hi`=0 at an edge) locks the result. A completion sampled at that same edge, or at any edge while locked, is discarded.
- R10: A high-byte read (`rd_en`=1, `rd_hi`=1) releases the lock. The next completion then updates both bytes together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_sel | input | 4 | Automatic trigger source code |
| auto_en | input | 1 | Enables automatic triggering |
| left_adj | input | 1 | Left-aligned result layout |
| sw_start | input | 1 | Software start request |
| trig_ev | input | 8 | Event pulses, bit i belongs to code i+1 |
| conv_done | input | 1 | Converter finished pulse |
| conv_data | input | 10 | Converter result |
| conv_start | output | 1 | Start pulse to the converter |
| busy | output | 1 | Conversion in progress |
| rd_en | input | 1 | Byte read strobe |
| rd_hi | input | 1 | Byte select, 1 = high byte |
| rd_data | output | 8 | Selected result byte |

## Verification
The hardest case to reach from the ports is a completion that lands in exactly the cycle of the low-byte read. In that case the byte being read and the lock are both decided at one edge. The stimulus drives `conv_done` and the low-byte strobe in the same cycle and then checks that the old value survives in both bytes. A second hard case is a flagged event that arrives while a conversion is running. The bench fires that event mid-conversion and predicts the start one edge after `busy` falls. It also confirms that an unlatched event sent at the same moment is lost.

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] trig_sel,
  input  logic       auto_en,
  input  logic       left_adj,
  input  logic       sw_start,
  input  logic [7:0] trig_ev,
  input  logic       conv_done,
  input  logic [9:0] conv_data,
  output logic       conv_start,
  output logic       busy,
  input  logic       rd_en,
  input  logic       rd_hi,
  output logic [7:0] rd_data
);
  localparam logic [7:0] FLAGGED = 8'b1100_1111;
  localparam logic [7:0] UNLATCH = 8'b0011_0000;

  logic [7:0] flag;
  logic [7:0] sel_vec;
  logic [7:0] clr;
  logic [9:0] res;
  logic       lock;
  logic       done_q;
  logic       lo_read;
  logic       hi_read;
  logic       free_go;
  logic       start_req;

  assign sel_vec = (trig_sel >= 4'd1 && trig_sel <= 4'd8) ? (8'd1 << (trig_sel - 4'd1)) : 8'd0;
  assign free_go = (trig_sel == 4'd0) && done_q;
  assign start_req = !busy && (sw_start || (auto_en && (free_go ||
                     |(sel_vec & FLAGGED & flag) || |(sel_vec & UNLATCH & trig_ev))));
  assign clr = start_req ? (sel_vec & FLAGGED) : 8'd0;
  assign lo_read = rd_en && !rd_hi;
  assign hi_read = rd_en && rd_hi;

  always_comb begin
    if (rd_hi) rd_data = left_adj ? res[9:2] : {6'b0, res[9:8]};
    else       rd_data = left_adj ? {res[1:0], 6'b0} : res[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      busy       <= 1'b0;
      done_q     <= 1'b0;
      flag       <= '0;
      lock       <= 1'b0;
      res        <= '0;
    end else begin
      conv_start <= start_req;
      if (start_req) busy <= 1'b1;
      else if (conv_done) busy <= 1'b0;
      done_q <= conv_done && busy;
      flag   <= (flag & ~clr) | (trig_ev & FLAGGED);
      if (hi_read) lock <= 1'b0;
      else if (lo_read) lock <= 1'b1;
      if (conv_done && busy && !lock && !lo_read) res <= conv_data;
    end
  end

  p_sw_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> busy);
  p_single_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel >= 4'd9) && !sw_start |=> !conv_start);
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(res));
  p_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !left_adj && rd_hi |-> rd_data[7:2] == 6'd0);
  p_lo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    left_adj && !rd_hi |-> rd_data[5:0] == 6'd0);
endmodule

// File: tb/adc_trig_ctrl_tb.sv
`timescale 1ns/1ps
module adc_trig_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] trig_sel = 0;
  logic auto_en = 0, left_adj = 0, sw_start = 0;
  logic [7:0] trig_ev = 0;
  logic conv_done = 0;
  logic [9:0] conv_data = 0;
  logic conv_start, busy;
  logic rd_en = 0, rd_hi = 0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$];

  adc_trig_ctrl u_dut (.clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .auto_en(auto_en),
    .left_adj(left_adj), .sw_start(sw_start), .trig_ev(trig_ev), .conv_done(conv_done),
    .conv_data(conv_data), .conv_start(conv_start), .busy(busy), .rd_en(rd_en),
    .rd_hi(rd_hi), .rd_data(rd_data));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected start", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(e == cyc, "R2-R5 start cycle", cyc, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_go();
    @(negedge clk); exp_q.push_back(cyc + 1); sw_start = 1;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic pulse_ev(input int b, input int lat);
    @(negedge clk);
    if (lat > 0) exp_q.push_back(cyc + lat);
    trig_ev[b] = 1;
    @(negedge clk); trig_ev = 0;
  endtask

  task automatic done(input logic [9:0] d, input int lat);
    @(negedge clk);
    if (lat > 0) exp_q.push_back(cyc + lat);
    conv_done = 1; conv_data = d;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic peek(input bit hi, output logic [7:0] v);
    rd_hi = hi; #1 v = rd_data;
  endtask

  task automatic rd(input bit hi, output logic [7:0] v);
    @(negedge clk); rd_en = 1; rd_hi = hi; #1 v = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3); rst_n = 1; idle(1);
    // R1
    chk(busy == 0, "R1 busy", busy, 0);
    peek(0, v); chk(v == 0, "R1 low", v, 0);
    peek(1, v); chk(v == 0, "R1 high", v, 0);

    // R2 software start, ignored while busy
    trig_sel = 4'd10;
    sw_go();
    chk(busy == 1, "R2 busy set", busy, 1);
    @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0;
    idle(2);
    chk(busy == 1, "R2 busy held", busy, 1);
    done(10'h2A5, 0);
    chk(busy == 0, "R2 busy cleared", busy, 0);
    // R7, R8 layouts
    peek(0, v); chk(v == 8'hA5, "R7 low", v, 8'hA5);
    peek(1, v); chk(v == 8'h02, "R7 high", v, 8'h02);
    left_adj = 1;
    peek(1, v); chk(v == 8'hA9, "R8 high", v, 8'hA9);
    peek(0, v); chk(v == 8'h40, "R8 low", v, 8'h40);
    left_adj = 0;

    // R4 flagged source, pending event while busy
    auto_en = 1; trig_sel = 4'd1;
    pulse_ev(0, 2); idle(1);
    chk(busy == 1, "R4 flagged start", busy, 1);
    done(10'h001, 0);
    trig_sel = 4'd7;
    pulse_ev(6, 2); idle(1);
    pulse_ev(6, 0);
    done(10'h002, 2);
    idle(2);
    chk(busy == 1, "R4 pending start", busy, 1);
    done(10'h003, 0);

    // R5 unlatched source, dropped when busy
    trig_sel = 4'd5;
    pulse_ev(4, 1);
    pulse_ev(4, 0);
    done(10'h004, 0);
    idle(3);
    chk(busy == 0, "R5 event dropped", busy, 0);

    // R6 reserved, wrong bit, disabled
    trig_sel = 4'd12; pulse_ev(4, 0); pulse_ev(5, 0); idle(2);
    chk(busy == 0, "R6 reserved", busy, 0);
    trig_sel = 4'd6; pulse_ev(4, 0); idle(2);
    chk(busy == 0, "R6 other bit", busy, 0);
    auto_en = 0; pulse_ev(5, 0); idle(2);
    chk(busy == 0, "R6 auto off", busy, 0);

    // R3 free running
    auto_en = 1; trig_sel = 4'd0;
    sw_go();
    done(10'h010, 2); idle(1);
    chk(busy == 1, "R3 restart", busy, 1);
    done(10'h011, 2); idle(1);
    auto_en = 0;
    done(10'h012, 0); idle(3);
    chk(busy == 0, "R3 stop", busy, 0);
    peek(0, v); chk(v == 8'h12, "R3 result", v, 8'h12);

    // R9 lock, R10 release
    trig_sel = 4'd10;
    rd(0, v); chk(v == 8'h12, "R9 low read", v, 8'h12);
    sw_go(); done(10'h3C7, 0);
    peek(0, v); chk(v == 8'h12, "R9 low frozen", v, 8'h12);
    peek(1, v); chk(v == 8'h00, "R9 high frozen", v, 8'h00);
    rd(1, v); chk(v == 8'h00, "R10 high read", v, 8'h00);
    sw_go(); done(10'h3C7, 0);
    peek(0, v); chk(v == 8'hC7, "R10 low update", v, 8'hC7);
    peek(1, v); chk(v == 8'h03, "R10 high update", v, 8'h03);
    // R9 same-edge completion is discarded
    sw_go();
    @(negedge clk); rd_en = 1; rd_hi = 0; conv_done = 1; conv_data = 10'h155;
    @(negedge clk); rd_en = 0; conv_done = 0;
    peek(0, v); chk(v == 8'hC7, "R9 same edge", v, 8'hC7);
    rd(1, v); chk(v == 8'h03, "R10 release", v, 8'h03);

    idle(4);
    chk(exp_q.size() == 0, "R2-R5 missing start", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule